// File: doc/BRIEF.md
# LIN Synch Break Detector

This block watches a serial receive line for the long low level that opens a LIN header. Software arms it with a start control bit. Once arming has taken effect, the block holds the line away from the companion UART receiver, so the UART sees a constant idle high. It then measures each low level with a down-counting timer that steps on a count-source enable pulse. A low level that lasts for the programmed number of count pulses is taken as a synch break. The block then raises a one-cycle timer interrupt request and sets a break status flag. A mask-select bit decides whether the input is released to the UART after the break.

Arming does not take effect at once. The receive input first crosses a synchroniser, and the arming itself waits one clock and then for a count-source pulse. Until the masked status flag reads 1, the line reaches the UART unchanged, so software must poll that flag before it relies on masking. A low level that ends early reloads the timer, and measurement starts again with the next low level. Three status flags share one write-one-to-clear port: bus collision, break and synch-field measurement. The collision and synch-field flags are set by neighbouring logic.

Top module: `lin_brk_detect`

## Requirements
- R1: A control write (`ctrl_we_i`=1) with `ctrl_start_i`=1 arms the block. `rxd_masked_o` rises at the first clock edge, counted from the second edge after the write edge, at which `cnt_en_i` is 1. A control write with `ctrl_start_i`=0 clears the armed state and `rxd_masked_o` at that same edge.
- R2: While `rxd_masked_o` is 0, `uart_rxd_o` equals the synchronised `rxd_i`. While it is 1, `uart_rxd_o` is held at 1.
- R3: `rxd_i` passes through two flip-flops before it is used. A value driven before edge k is seen by the measuring logic at edge k+2. Measurement runs only while `rxd_masked_o` and `timer_busy_o` are both 1.
- R4: `timer_busy_o` rises at the first edge with `cnt_en_i`=1 while `timer_go_i`=1. It falls at the first edge with `timer_go_i`=0.
- R5: With reload value N≥1, a break is N consecutive count pulses that all see a low synchronised line. With `cnt_en_i` held at 1 and the line first driven low before edge a, `irq_o` is 1 for exactly the one cycle after edge a+N+1. After a detection the timer is loaded again with N.
- R6: The break flag `status_o[1]` is set at the edge after the edge that raises `irq_o`.
- R7: Any high sample of the synchronised line during measurement reloads the timer with N. So N−1 low cycles, then a high, then N−1 low cycles, produce no break.
- R8: With `ctrl_hold_i`=0, the block disarms and drops `rxd_masked_o` at the same edge that sets the break flag. With `ctrl_hold_i`=1, `rxd_masked_o` stays 1 and no further break is detected until the block is disarmed and armed again.
- R9: `status_o` bit 0 is collision (set by `coll_set_i`), bit 1 is break, and bit 2 is synch-field (set by `field_set_i`). Writing `clr_we_i`=1 with `clr_i[k]`=1 clears bit k at the next edge. If a set and a clear reach the same bit in the same cycle, the set wins.
- R10: After reset, `status_o`=0, `rxd_masked_o`=0, `timer_busy_o`=0, `irq_o`=0 and `uart_rxd_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count-source enable pulse |
| rxd_i | input | 1 | Raw serial receive line |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_start_i | input | 1 | Start bit value for the control write |
| ctrl_hold_i | input | 1 | Mask select: 1 keeps the input masked after a break |
| timer_go_i | input | 1 | Timer run control |
| reload_i | input | CNT_W | Programmed break length, in count pulses |
| clr_we_i | input | 1 | Status clear strobe |
| clr_i | input | 3 | Write-one-to-clear bits per status flag |
| coll_set_i | input | 1 | Sets the collision flag |
| field_set_i | input | 1 | Sets the synch-field flag |
| uart_rxd_o | output | 1 | Receive line as passed to the UART |
| rxd_masked_o | output | 1 | Masking-active status flag |
| timer_busy_o | output | 1 | Timer counting-status flag |
| irq_o | output | 1 | Timer interrupt request, one cycle per break |
| status_o | output | 3 | Collision, break and synch-field flags |

## Verification
Two events can fall in the same cycle. In one, a break sets the break flag while software writes the clear bit for that flag. In the other, the collision set pulse and its clear bit arrive together. The bench provokes the first by driving the clear so that it meets the edge one cycle after `irq_o` rises, and the second by pulsing `coll_set_i` and `clr_i[0]` in one cycle. In both cases the flag must read 1 afterwards. A separate step clears each flag alone, which shows that the clear path works in its own right.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;
  localparam int unsigned N_FLAGS = 3;
  localparam int unsigned ST_COLL  = 0;
  localparam int unsigned ST_BRK   = 1;
  localparam int unsigned ST_FIELD = 2;
  typedef logic [N_FLAGS-1:0] flags_t;
endpackage

// File: rtl/lin_brk_sync.sv
module lin_brk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= 1'b1;  // idle line is high
        else if (i == 0) chain_q[i] <= d_i;
        else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lin_brk_arm.sv
module lin_brk_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_we_i,
  input  logic ctrl_start_i,
  input  logic hold_i,
  input  logic cnt_en_i,
  input  logic det_i,
  output logic masked_o
);
  logic armed_q, arm_d_q, masked_q;
  logic disarm, release_brk;

  assign disarm      = ctrl_we_i & ~ctrl_start_i;
  assign release_brk = det_i & ~hold_i & masked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      arm_d_q  <= 1'b0;
      masked_q <= 1'b0;
    end else begin
      if (ctrl_we_i)        armed_q <= ctrl_start_i;
      else if (release_brk) armed_q <= 1'b0;
      arm_d_q <= armed_q & ~disarm & ~release_brk;
      if (disarm || release_brk)                 masked_q <= 1'b0;
      else if (armed_q && arm_d_q && cnt_en_i)   masked_q <= 1'b1;
    end
  end

  assign masked_o = masked_q;

  AST_MASK_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    masked_q |-> armed_q);  // R1
  AST_ARM_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |=> !masked_q);  // R1
  AST_UNMASK_AFTER_BRK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_i && !hold_i && masked_q) |=> !masked_q);  // R8
endmodule

// File: rtl/lin_brk_timer.sv
module lin_brk_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             go_i,
  input  logic             masked_i,
  input  logic             rxd_s_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             busy_o,
  output logic             det_o
);
  logic             busy_q, done_q, det_q;
  logic [CNT_W-1:0] cnt_q;
  logic             meas, det_now;

  assign meas    = masked_i & busy_q & ~done_q;
  assign det_now = meas & ~rxd_s_i & cnt_en_i & (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      det_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= go_i & (busy_q | cnt_en_i);
      done_q <= masked_i & (done_q | det_now);  // one break per arming
      det_q  <= det_now;
      if (!meas || rxd_s_i || det_now) cnt_q <= reload_i;  // short low reloads
      else if (cnt_en_i)               cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o = busy_q;
  assign det_o  = det_q;

  AST_BUSY_NEEDS_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> $past(go_i));  // R4
  AST_DET_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_q |=> !det_q);  // R5
  AST_NO_DET_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !masked_i |=> !det_q);  // R3
endmodule

// File: rtl/lin_brk_flags.sv
module lin_brk_flags
  import lin_brk_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  flags_t set_i,
  input  flags_t clr_i,
  output flags_t flags_o
);
  flags_t flag_q;

  generate
    for (genvar k = 0; k < N_FLAGS; k++) begin : g_flag
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       flag_q[k] <= 1'b0;
        else if (set_i[k]) flag_q[k] <= 1'b1;  // set beats clear
        else if (clr_i[k]) flag_q[k] <= 1'b0;
      end

      AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[k] |=> flag_q[k]);  // R9
      AST_FLAG_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i[k] && !set_i[k]) |=> !flag_q[k]);  // R9
    end
  endgenerate

  assign flags_o = flag_q;
endmodule

// File: rtl/lin_brk_detect.sv
module lin_brk_detect
  import lin_brk_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cnt_en_i,
  input  logic               rxd_i,
  input  logic               ctrl_we_i,
  input  logic               ctrl_start_i,
  input  logic               ctrl_hold_i,
  input  logic               timer_go_i,
  input  logic [CNT_W-1:0]   reload_i,
  input  logic               clr_we_i,
  input  logic [N_FLAGS-1:0] clr_i,
  input  logic               coll_set_i,
  input  logic               field_set_i,
  output logic               uart_rxd_o,
  output logic               rxd_masked_o,
  output logic               timer_busy_o,
  output logic               irq_o,
  output logic [N_FLAGS-1:0] status_o
);
  logic   rxd_s, masked, det;
  flags_t set_v, clr_v;

  lin_brk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(rxd_i), .q_o(rxd_s)
  );

  lin_brk_arm u_arm (
    .clk_i, .rst_ni, .ctrl_we_i, .ctrl_start_i, .hold_i(ctrl_hold_i),
    .cnt_en_i, .det_i(det), .masked_o(masked)
  );

  lin_brk_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .cnt_en_i, .go_i(timer_go_i), .masked_i(masked),
    .rxd_s_i(rxd_s), .reload_i, .busy_o(timer_busy_o), .det_o(det)
  );

  always_comb begin
    set_v           = '0;
    set_v[ST_COLL]  = coll_set_i;
    set_v[ST_BRK]   = det;
    set_v[ST_FIELD] = field_set_i;
    clr_v           = clr_we_i ? clr_i : '0;
  end

  lin_brk_flags u_flags (
    .clk_i, .rst_ni, .set_i(set_v), .clr_i(clr_v), .flags_o(status_o)
  );

  assign uart_rxd_o   = masked ? 1'b1 : rxd_s;
  assign rxd_masked_o = masked;
  assign irq_o        = det;

  AST_MASKED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxd_masked_o |-> uart_rxd_o);  // R2
  AST_IRQ_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> status_o[ST_BRK]);  // R6
endmodule

// File: tb/lin_brk_detect_test.sv
module lin_brk_detect_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cnt_en = 1'b1, rxd = 1'b1, ctrl_we = 1'b0, ctrl_start = 1'b0, ctrl_hold = 1'b0;
  logic go = 1'b0, clr_we = 1'b0, coll_set = 1'b0, field_set = 1'b0;
  logic [7:0] reload = 8'd4;
  logic [2:0] clr = 3'b000;
  logic uart_rxd, masked, busy, irq;
  logic [2:0] status;
  int checks = 0, fails = 0;
  bit finished = 0;

  typedef struct packed {logic [7:0] n; logic [7:0] len; logic hold; logic brk;} vec_t;
  localparam vec_t VECS [7] = '{
    '{8'd4, 8'd3, 1'b0, 1'b0}, '{8'd4, 8'd4, 1'b0, 1'b1}, '{8'd4, 8'd9, 1'b0, 1'b1},
    '{8'd2, 8'd2, 1'b1, 1'b1}, '{8'd3, 8'd2, 1'b1, 1'b0}, '{8'd6, 8'd6, 1'b1, 1'b1},
    '{8'd6, 8'd5, 1'b0, 1'b0}};

  always #5 clk = ~clk;

  lin_brk_detect uut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en), .rxd_i(rxd), .ctrl_we_i(ctrl_we),
    .ctrl_start_i(ctrl_start), .ctrl_hold_i(ctrl_hold), .timer_go_i(go), .reload_i(reload),
    .clr_we_i(clr_we), .clr_i(clr), .coll_set_i(coll_set), .field_set_i(field_set),
    .uart_rxd_o(uart_rxd), .rxd_masked_o(masked), .timer_busy_o(busy), .irq_o(irq),
    .status_o(status)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctrl_write(logic start, logic hold);
    ctrl_start = start; ctrl_hold = hold; ctrl_we = 1'b1;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic clear_all();
    clr = 3'b111; clr_we = 1'b1;
    @(negedge clk); clr_we = 1'b0; clr = 3'b000;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(2);
    // R10 reset state
    chk("R10 status", {5'd0, status}, 8'd0);
    chk("R10 masked", {7'd0, masked}, 8'd0);
    chk("R10 busy", {7'd0, busy}, 8'd0);
    chk("R10 irq", {7'd0, irq}, 8'd0);
    chk("R10 uart", {7'd0, uart_rxd}, 8'd1);
    rst_n = 1'b1;
    idle(1);

    // R4 busy waits for a count pulse
    cnt_en = 1'b0; go = 1'b1; idle(2);
    chk("R4 busy without pulse", {7'd0, busy}, 8'd0);
    cnt_en = 1'b1; idle(1);
    chk("R4 busy after pulse", {7'd0, busy}, 8'd1);
    go = 1'b0; idle(1);
    chk("R4 busy drops", {7'd0, busy}, 8'd0);
    go = 1'b1; idle(1);

    // R1 R2 R3 arming window passes the line through
    cnt_en = 1'b0; rxd = 1'b0; idle(3);
    ctrl_write(1'b1, 1'b1);
    chk("R1 not yet masked", {7'd0, masked}, 8'd0);
    chk("R2 passthrough low", {7'd0, uart_rxd}, 8'd0);
    idle(2);
    chk("R1 waits count source", {7'd0, masked}, 8'd0);
    cnt_en = 1'b1; idle(1);
    chk("R1 masked", {7'd0, masked}, 8'd1);
    chk("R2 held high", {7'd0, uart_rxd}, 8'd1);
    ctrl_write(1'b0, 1'b1);
    chk("R1 disarm clears mask", {7'd0, masked}, 8'd0);
    rxd = 1'b1; idle(3); clear_all();
    chk("R3 line back high", {7'd0, uart_rxd}, 8'd1);

    // R5 R6 R9 R8 exact timing, set against clear, hold=1
    reload = 8'd4;
    ctrl_write(1'b1, 1'b1); idle(3);
    rxd = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R5 irq raised", {7'd0, irq}, 8'd1);
    chk("R6 flag not yet", {7'd0, status[1]}, 8'd0);
    clr = 3'b010; clr_we = 1'b1;
    @(negedge clk); clr_we = 1'b0; clr = 3'b000;
    chk("R5 irq one cycle", {7'd0, irq}, 8'd0);
    chk("R9 set wins over clear", {7'd0, status[1]}, 8'd1);
    chk("R8 hold keeps mask", {7'd0, masked}, 8'd1);
    clear_all();
    chk("R9 break cleared", {7'd0, status[1]}, 8'd0);
    idle(8);
    chk("R8 no second break", {7'd0, status[1]}, 8'd0);
    rxd = 1'b1; ctrl_write(1'b0, 1'b0); idle(3); clear_all();

    // R7 short lows reload the timer, then R8 hold=0 releases
    ctrl_write(1'b1, 1'b0); idle(3);
    rxd = 1'b0; idle(3); rxd = 1'b1; idle(1); rxd = 1'b0; idle(3); rxd = 1'b1; idle(8);
    chk("R7 no break from short lows", {7'd0, status[1]}, 8'd0);
    rxd = 1'b0; idle(4); rxd = 1'b1; idle(6);
    chk("R7 full low breaks", {7'd0, status[1]}, 8'd1);
    chk("R8 released after break", {7'd0, masked}, 8'd0);
    clear_all();

    // R9 collision and field flags
    coll_set = 1'b1; field_set = 1'b1; idle(1); coll_set = 1'b0; field_set = 1'b0;
    chk("R9 coll and field set", {5'd0, status}, 8'h05);
    clr = 3'b001; clr_we = 1'b1; idle(1); clr_we = 1'b0;
    chk("R9 clear coll only", {5'd0, status}, 8'h04);
    coll_set = 1'b1; clr = 3'b101; clr_we = 1'b1; idle(1);
    coll_set = 1'b0; clr_we = 1'b0; clr = 3'b000;
    chk("R9 coll set beats clear", {5'd0, status}, 8'h01);
    clear_all();

    // table walk: R5 R7 R8
    foreach (VECS[i]) begin
      reload = VECS[i].n;
      ctrl_write(1'b0, 1'b0); rxd = 1'b1; idle(3); clear_all();
      ctrl_write(1'b1, VECS[i].hold); idle(3);
      rxd = 1'b0; idle(int'(VECS[i].len)); rxd = 1'b1;
      idle(int'(VECS[i].n) + 4);
      chk($sformatf("R5 vec%0d break", i), {7'd0, status[1]}, {7'd0, VECS[i].brk});
      chk($sformatf("R8 vec%0d mask", i), {7'd0, masked},
          {7'd0, VECS[i].brk ? VECS[i].hold : 1'b1});
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule